// File: doc/BRIEF.md
# Zero-Page Bit Operation and Bit Test Execution Unit

This unit executes the single-bit and bit-mask instructions of an 8-bit accumulator processor. The core's decoder hands it the opcode byte, the accumulator, the status flags, an operand address, a branch displacement, an immediate byte and the program counter value reached after all operand bytes were fetched. The unit then works through a synchronous memory port on its own. It clears or sets one bit of a zero-page byte, or tests one bit of that byte and decides a relative branch. It also merges or strips the accumulator's bits into a memory byte, or tests memory against the accumulator.

A one-cycle `start` launches an operation while the unit is idle. `busy` stays high until the cycle that carries the `done` pulse. In that cycle, and from then until the next accepted start, `flags_out`, `br_taken` and `br_target` hold the result. Memory reads are synchronous: data requested in one cycle is presented on `mem_rdata` in the next. The per-bit instructions are padded to a fixed length so the core can schedule them as a block.

Top module: `bmx_unit`

## Requirements
- R1: After reset, `busy`, `done`, `mem_rd`, `mem_wr` and `br_taken` are 0 and `flags_out` is 0. Flag bits are ordered bit 2 = N, bit 1 = V, bit 0 = Z, on both `flags_in` and `flags_out`.
- R2: An opcode with low nibble 0x7 selects a bit index from opcode bits 6:4. With opcode bit 7 = 0 the unit writes the byte back with that bit cleared (reset-bit form). With bit 7 = 1 it writes the byte back with that bit set (set-bit form). All other bits are kept and the flags are returned unchanged.
- R3: An opcode with low nibble 0xF tests the bit selected by opcode bits 6:4. With opcode bit 7 = 0 the branch is taken when the bit is 0; with bit 7 = 1 it is taken when the bit is 1. `br_target` = `pc_in` + the sign-extended `disp`, where `pc_in` already points past both operand bytes. The flags are unchanged and there is no write.
- R4: Every bit-index form (low nibble 0x7 or 0xF) accesses address {0, `op_addr[7:0]`}. The upper address bits are always zero.
- R5: Every bit-index form raises `done` in the BITOP_CYCLES-th cycle after the start cycle (default 5).
- R6: Opcodes 0x04/0x0C (test-and-set) write M | A. Opcodes 0x14/0x1C (test-and-reset) write M & ~A. Both set Z = ((A & M) == 0), keep N and V, and raise `done` in the 4th cycle after start.
- R7: Memory bit-test opcodes 0x24/0x2C/0x34/0x3C set Z = ((A & M) == 0), N = M bit 7 and V = M bit 6. They do not write and raise `done` in the 3rd cycle.
- R8: The immediate bit test 0x89 uses `imm` as M and sets Z only, keeping N and V. It makes no memory access and raises `done` in the 2nd cycle.
- R9: Every read-modify-write form makes exactly one read and then exactly one write to the same address, two cycles apart. Read and write are never requested in the same cycle.
- R10: `start` is ignored while `busy` is high. It affects neither memory nor the result, and it produces no extra `done`.
- R11: Any other opcode makes no memory access, returns the flags unchanged, does not branch, and raises `done` in the 2nd cycle.
- R12: `done` is high for exactly one cycle, and `busy` is low in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation (taken only when idle) |
| opcode | input | 8 | Opcode byte |
| acc | input | 8 | Accumulator value |
| imm | input | 8 | Immediate operand |
| op_addr | input | ADDR_W | Operand address |
| disp | input | 8 | Signed branch displacement |
| pc_in | input | ADDR_W | PC after all operand bytes |
| flags_in | input | 3 | Current N, V, Z |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Result valid pulse |
| flags_out | output | 3 | Resulting N, V, Z |
| br_taken | output | 1 | Branch decision |
| br_target | output | ADDR_W | Branch destination |

## Verification
The bound checker watches every cycle for the timing and access shape of an operation. It confirms that read and write never overlap, and that each write repeats the address of a read two cycles earlier. It confirms that zero-page addressing is used for the bit-index forms, that those forms finish at the padded length with their flags untouched, and that only they can branch and `done` is a single pulse. Data values cannot be checked that way. The written byte for each bit index and mask, the Z/N/V results of the test-and-modify and bit-test forms, and branch targets with negative and positive displacements are shown only by the directed scenarios. The same holds for the dropped start during a busy operation.

// File: rtl/bmx_pkg.sv
package bmx_pkg;

   localparam int FL_Z = 0;
   localparam int FL_V = 1;
   localparam int FL_N = 2;

   typedef enum logic [3:0] {
      K_NONE, K_RMB, K_SMB, K_BBR, K_BBS, K_TSB, K_TRB, K_BITM, K_BITI
   } bmx_kind_e;

   function automatic bmx_kind_e bmx_classify(input logic [7:0] op);
      bmx_kind_e k;
      k = K_NONE;
      if (op[3:0] == 4'h7)      k = op[7] ? K_SMB : K_RMB;
      else if (op[3:0] == 4'hF) k = op[7] ? K_BBS : K_BBR;
      else begin
         case (op)
            8'h04, 8'h0C:               k = K_TSB;
            8'h14, 8'h1C:               k = K_TRB;
            8'h24, 8'h2C, 8'h34, 8'h3C: k = K_BITM;
            8'h89:                      k = K_BITI;
            default:                    k = K_NONE;
         endcase
      end
      return k;
   endfunction

   function automatic logic kind_uses_mem(input bmx_kind_e k);
      return (k != K_NONE) && (k != K_BITI);
   endfunction

   function automatic logic kind_writes(input bmx_kind_e k);
      return (k == K_RMB) || (k == K_SMB) || (k == K_TSB) || (k == K_TRB);
   endfunction

   function automatic logic kind_is_bitop(input bmx_kind_e k);
      return (k == K_RMB) || (k == K_SMB) || (k == K_BBR) || (k == K_BBS);
   endfunction

endpackage

// File: rtl/bmx_decode.sv
module bmx_decode
   import bmx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [7:0]        opcode,
   output bmx_kind_e         kind,
   output logic [DATA_W-1:0] mask
);
   localparam int IDX_W = 3;

   assign kind = bmx_classify(opcode);

   for (genvar i = 0; i < DATA_W; i++) begin : g_mask
      assign mask[i] = (opcode[6:4] == IDX_W'(i));
   end
endmodule

// File: rtl/bmx_alu.sv
module bmx_alu
   import bmx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 16
) (
   input  bmx_kind_e         kind,
   input  logic [DATA_W-1:0] mask,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] operand,
   input  logic [2:0]        flags_in,
   input  logic [ADDR_W-1:0] pc,
   input  logic [7:0]        disp,
   output logic [DATA_W-1:0] wdata,
   output logic [2:0]        flags,
   output logic              take,
   output logic [ADDR_W-1:0] target
);
   localparam int EXT_W = ADDR_W - 8;

   logic [ADDR_W-1:0] disp_ext;
   logic              none_common;

   if (EXT_W > 0) begin : g_sext
      assign disp_ext = {{EXT_W{disp[7]}}, disp};
   end else begin : g_nosext
      assign disp_ext = disp[ADDR_W-1:0];
   end

   assign target      = pc + disp_ext;
   assign none_common = ~|(acc & operand);

   always_comb begin
      wdata = operand;
      flags = flags_in;
      take  = 1'b0;
      case (kind)
         K_RMB:  wdata = operand & ~mask;
         K_SMB:  wdata = operand | mask;
         K_BBR:  take  = ~|(operand & mask);
         K_BBS:  take  = |(operand & mask);
         K_TSB: begin
            wdata       = operand | acc;
            flags[FL_Z] = none_common;
         end
         K_TRB: begin
            wdata       = operand & ~acc;
            flags[FL_Z] = none_common;
         end
         K_BITM: begin
            flags[FL_Z] = none_common;
            flags[FL_N] = operand[DATA_W-1];
            flags[FL_V] = operand[DATA_W-2];
         end
         K_BITI: flags[FL_Z] = none_common;
         default: ;
      endcase
   end
endmodule

// File: rtl/bmx_seq.sv
module bmx_seq
   import bmx_pkg::*;
#(
   parameter int BITOP_CYCLES = 5
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  bmx_kind_e kind_in,
   output bmx_kind_e kind_q,
   output logic      accept,
   output logic      busy,
   output logic      done,
   output logic      rd,
   output logic      wr,
   output logic      exe
);
   localparam int CYC_W = $clog2(BITOP_CYCLES + 1);
   localparam logic [CYC_W-1:0] LAST_WORK = CYC_W'(BITOP_CYCLES - 1);

   typedef enum logic [2:0] {S_IDLE, S_RD, S_EXE, S_WR, S_PAD, S_DONE} st_e;

   st_e              st;
   logic [CYC_W-1:0] cyc;
   logic             pad_done;

   assign busy     = (st != S_IDLE);
   assign accept   = start && !busy;
   assign rd       = (st == S_RD);
   assign exe      = (st == S_EXE);
   assign wr       = (st == S_WR);
   assign done     = (st == S_DONE);
   assign pad_done = (cyc >= LAST_WORK);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         cyc    <= '0;
         kind_q <= K_NONE;
      end else begin
         if (busy) cyc <= cyc + 1'b1;
         case (st)
            S_IDLE: if (start) begin
               kind_q <= kind_in;
               cyc    <= CYC_W'(1);
               st     <= kind_uses_mem(kind_in) ? S_RD : S_EXE;
            end
            S_RD:  st <= S_EXE;
            S_EXE: begin
               if (kind_writes(kind_q))        st <= S_WR;
               else if (kind_is_bitop(kind_q)) st <= pad_done ? S_DONE : S_PAD;
               else                            st <= S_DONE;
            end
            S_WR: begin
               if (kind_is_bitop(kind_q) && !pad_done) st <= S_PAD;
               else                                    st <= S_DONE;
            end
            S_PAD:  if (pad_done) st <= S_DONE;
            S_DONE: st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bmx_unit.sv
module bmx_unit
   import bmx_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int BITOP_CYCLES = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [7:0]        opcode,
   input  logic [7:0]        acc,
   input  logic [7:0]        imm,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [7:0]        disp,
   input  logic [ADDR_W-1:0] pc_in,
   input  logic [2:0]        flags_in,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              busy,
   output logic              done,
   output logic [2:0]        flags_out,
   output logic              br_taken,
   output logic [ADDR_W-1:0] br_target
);
   localparam int DATA_W = 8;
   localparam int ZP_W   = 8;
   localparam int HI_W   = ADDR_W - ZP_W;

   if (ADDR_W < ZP_W + 1) begin : g_bad_addr
      $error("bmx_unit: ADDR_W must exceed the zero-page width");
   end
   if (BITOP_CYCLES < 4) begin : g_bad_len
      $error("bmx_unit: BITOP_CYCLES must be at least 4");
   end

   bmx_kind_e         kind_in, kind_q, kind_dec;
   logic              accept, exe;
   logic [7:0]        op_q, a_q, imm_q, disp_q;
   logic [ADDR_W-1:0] addr_q, pc_q;
   logic [2:0]        fl_q;
   logic [DATA_W-1:0] mask, operand, alu_wdata;
   logic [2:0]        alu_flags;
   logic              alu_take;
   logic [ADDR_W-1:0] alu_target;

   assign kind_in = bmx_classify(opcode);

   bmx_seq #(.BITOP_CYCLES(BITOP_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .kind_in(kind_in),
      .kind_q(kind_q), .accept(accept), .busy(busy), .done(done),
      .rd(mem_rd), .wr(mem_wr), .exe(exe)
   );

   bmx_decode #(.DATA_W(DATA_W)) u_dec (
      .opcode(op_q), .kind(kind_dec), .mask(mask)
   );

   assign operand = kind_uses_mem(kind_q) ? mem_rdata : imm_q;

   bmx_alu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_alu (
      .kind(kind_q), .mask(mask), .acc(a_q), .operand(operand),
      .flags_in(fl_q), .pc(pc_q), .disp(disp_q),
      .wdata(alu_wdata), .flags(alu_flags), .take(alu_take), .target(alu_target)
   );

   assign mem_addr = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q      <= '0;
         a_q       <= '0;
         imm_q     <= '0;
         disp_q    <= '0;
         addr_q    <= '0;
         pc_q      <= '0;
         fl_q      <= '0;
         mem_wdata <= '0;
         flags_out <= '0;
         br_taken  <= 1'b0;
         br_target <= '0;
      end else begin
         if (accept) begin
            op_q   <= opcode;
            a_q    <= acc;
            imm_q  <= imm;
            disp_q <= disp;
            pc_q   <= pc_in;
            fl_q   <= flags_in;
            addr_q <= kind_is_bitop(kind_in) ? {{HI_W{1'b0}}, op_addr[ZP_W-1:0]} : op_addr;
         end
         if (exe && (kind_dec == kind_q)) begin
            mem_wdata <= alu_wdata;
            flags_out <= alu_flags;
            br_taken  <= alu_take;
            br_target <= alu_target;
         end
      end
   end
endmodule

// File: rtl/bmx_chk.sv
module bmx_chk #(
   parameter int ADDR_W       = 16,
   parameter int BITOP_CYCLES = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [7:0]        opcode,
   input logic [2:0]        flags_in,
   input logic              mem_rd,
   input logic              mem_wr,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              busy,
   input logic              done,
   input logic [2:0]        flags_out,
   input logic              br_taken
);
   logic       bitop_q;
   logic [2:0] fl_seen;
   logic [7:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bitop_q <= 1'b0;
         fl_seen <= '0;
         cnt     <= '0;
      end else if (start && !busy) begin
         bitop_q <= (opcode[3:0] == 4'h7) || (opcode[3:0] == 4'hF);
         fl_seen <= flags_in;
         cnt     <= 8'd1;
      end else if (busy) begin
         cnt <= cnt + 8'd1;
      end
   end

   // R9
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R9
   wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> ($past(mem_rd, 2) && (mem_addr == $past(mem_addr, 2))));

   // R4
   zp_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bitop_q && (mem_rd || mem_wr)) |-> (mem_addr[ADDR_W-1:8] == '0));

   // R5
   bitop_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && bitop_q) |-> (cnt == 8'(BITOP_CYCLES)));

   // R2
   bitop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && bitop_q) |-> (flags_out == fl_seen));

   // R3
   branch_only_bitop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && br_taken) |-> bitop_q);

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));
endmodule

bind bmx_unit bmx_chk #(.ADDR_W(ADDR_W), .BITOP_CYCLES(BITOP_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
   .flags_in(flags_in), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
   .busy(busy), .done(done), .flags_out(flags_out), .br_taken(br_taken)
);

// File: tb/sim_bmx_unit.sv
`timescale 1ns/1ps
module sim_bmx_unit;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [7:0]    opcode = '0, acc = '0, imm = '0, disp = '0;
   logic [AW-1:0] op_addr = '0, pc_in = '0;
   logic [2:0]    flags_in = '0;
   logic          mem_rd, mem_wr, busy, done, br_taken;
   logic [AW-1:0] mem_addr, br_target;
   logic [7:0]    mem_wdata, mem_rdata;
   logic [2:0]    flags_out;

   logic [7:0]    mem [256];
   logic [7:0]    rdq = '0;
   int            nrd, nwr, ndone, lat, vecs, bad;
   logic [AW-1:0] last_addr;

   always #2 clk = ~clk;

   bmx_unit u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .acc(acc),
      .imm(imm), .op_addr(op_addr), .disp(disp), .pc_in(pc_in),
      .flags_in(flags_in), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .flags_out(flags_out), .br_taken(br_taken),
      .br_target(br_target)
   );

   assign mem_rdata = rdq;

   always @(posedge clk) begin
      if (mem_rd) rdq <= mem[mem_addr[7:0]];
      if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
   end

   always @(negedge clk) begin
      if (mem_rd) begin nrd++; last_addr = mem_addr; end
      if (mem_wr) begin nwr++; last_addr = mem_addr; end
      if (done) ndone++;
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      vecs++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic launch(input logic [7:0] op, input logic [7:0] a, input logic [7:0] im,
                         input logic [AW-1:0] ad, input logic [7:0] d,
                         input logic [AW-1:0] pc, input logic [2:0] fl);
      @(negedge clk);
      nrd = 0; nwr = 0; ndone = 0;
      opcode = op; acc = a; imm = im; op_addr = ad; disp = d; pc_in = pc; flags_in = fl;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
   endtask

   task automatic finish_op;
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      if (!done) check("R12", "done never seen", 0, 1);
   endtask

   task automatic run_op(input logic [7:0] op, input logic [7:0] a, input logic [7:0] im,
                         input logic [AW-1:0] ad, input logic [7:0] d,
                         input logic [AW-1:0] pc, input logic [2:0] fl);
      launch(op, a, im, ad, d, pc, fl);
      finish_op();
   endtask

   task automatic t_reset;
      check("R1", "busy", int'(busy), 0);
      check("R1", "done", int'(done), 0);
      check("R1", "rd/wr", int'({mem_rd, mem_wr}), 0);
      check("R1", "flags_out", int'(flags_out), 0);
      check("R1", "br_taken", int'(br_taken), 0);
   endtask

   task automatic t_rmb_smb;
      mem[8'h40] = 8'hFF;
      run_op(8'h37, 8'h00, 8'h00, 16'h1240, 8'h00, 16'h0000, 3'b101);
      check("R2", "RMB3 byte", int'(mem[8'h40]), 8'hF7);
      check("R2", "RMB3 flags", int'(flags_out), 3'b101);
      check("R5", "RMB latency", lat, 5);
      check("R9", "RMB reads", nrd, 1);
      check("R9", "RMB writes", nwr, 1);
      check("R4", "RMB zp address", int'(last_addr), 16'h0040);
      mem[8'h41] = 8'h00;
      run_op(8'hE7, 8'h00, 8'h00, 16'h0041, 8'h00, 16'h0000, 3'b010);
      check("R2", "SMB6 byte", int'(mem[8'h41]), 8'h40);
      check("R2", "SMB6 flags", int'(flags_out), 3'b010);
      check("R5", "SMB latency", lat, 5);
      mem[8'h42] = 8'h5A;
      run_op(8'h07, 8'hFF, 8'h00, 16'h0042, 8'h00, 16'h0000, 3'b000);
      check("R2", "RMB0 no change", int'(mem[8'h42]), 8'h5A);
   endtask

   task automatic t_branch;
      mem[8'h50] = 8'hDF;
      run_op(8'h5F, 8'h00, 8'h00, 16'hAB50, 8'hF0, 16'h0305, 3'b111);
      check("R3", "BBR5 taken", int'(br_taken), 1);
      check("R3", "BBR5 target", int'(br_target), 16'h02F5);
      check("R3", "BBR5 flags", int'(flags_out), 3'b111);
      check("R3", "BBR5 writes", nwr, 0);
      check("R5", "BBR latency", lat, 5);
      check("R4", "BBR zp address", int'(last_addr), 16'h0050);
      run_op(8'hDF, 8'h00, 8'h00, 16'h0050, 8'h10, 16'h0305, 3'b000);
      check("R3", "BBS5 not taken", int'(br_taken), 0);
      mem[8'h51] = 8'h80;
      run_op(8'hFF, 8'h00, 8'h00, 16'h0051, 8'h7F, 16'hFFF0, 3'b000);
      check("R3", "BBS7 taken", int'(br_taken), 1);
      check("R3", "BBS7 target wrap", int'(br_target), 16'h006F);
      check("R5", "BBS latency", lat, 5);
   endtask

   task automatic t_tsb_trb;
      mem[8'h60] = 8'hF0;
      run_op(8'h0C, 8'h0F, 8'h00, 16'h0060, 8'h00, 16'h0000, 3'b110);
      check("R6", "TSB byte", int'(mem[8'h60]), 8'hFF);
      check("R6", "TSB flags", int'(flags_out), 3'b111);
      check("R6", "TSB latency", lat, 4);
      check("R9", "TSB reads", nrd, 1);
      check("R9", "TSB writes", nwr, 1);
      mem[8'h61] = 8'h3C;
      run_op(8'h14, 8'h0F, 8'h00, 16'h0061, 8'h00, 16'h0000, 3'b001);
      check("R6", "TRB byte", int'(mem[8'h61]), 8'h30);
      check("R6", "TRB flags", int'(flags_out), 3'b000);
   endtask

   task automatic t_bit;
      mem[8'h70] = 8'hC0;
      run_op(8'h2C, 8'h01, 8'h00, 16'h0070, 8'h00, 16'h0000, 3'b000);
      check("R7", "BIT flags", int'(flags_out), 3'b111);
      check("R7", "BIT latency", lat, 3);
      check("R7", "BIT writes", nwr, 0);
      mem[8'h71] = 8'h3F;
      run_op(8'h24, 8'h01, 8'h00, 16'h0071, 8'h00, 16'h0000, 3'b111);
      check("R7", "BIT flags nonzero", int'(flags_out), 3'b000);
      run_op(8'h89, 8'h01, 8'hC0, 16'h0070, 8'h00, 16'h0000, 3'b010);
      check("R8", "BIT imm flags", int'(flags_out), 3'b011);
      check("R8", "BIT imm accesses", nrd + nwr, 0);
      check("R8", "BIT imm latency", lat, 2);
   endtask

   task automatic t_other;
      run_op(8'hEA, 8'hFF, 8'h00, 16'h0070, 8'h05, 16'h0100, 3'b101);
      check("R11", "flags", int'(flags_out), 3'b101);
      check("R11", "accesses", nrd + nwr, 0);
      check("R11", "branch", int'(br_taken), 0);
      check("R11", "latency", lat, 2);
   endtask

   task automatic t_busy_start;
      mem[8'h80] = 8'h01;
      mem[8'h81] = 8'hFF;
      launch(8'h04, 8'h10, 8'h00, 16'h0080, 8'h00, 16'h0000, 3'b000);
      opcode = 8'h14; acc = 8'hFF; op_addr = 16'h0081; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat++;
      finish_op();
      check("R10", "first op byte", int'(mem[8'h80]), 8'h11);
      check("R10", "latency", lat, 4);
      @(negedge clk);
      check("R12", "busy after done", int'(busy), 0);
      repeat (6) @(negedge clk);
      check("R10", "ignored target byte", int'(mem[8'h81]), 8'hFF);
      check("R10", "done count", ndone, 1);
      check("R10", "writes", nwr, 1);
   endtask

   initial begin
      #400000;
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end

   initial begin
      vecs = 0; bad = 0;
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_rmb_smb();
      t_branch();
      t_tsb_trb();
      t_bit();
      t_other();
      t_busy_start();
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end
endmodule